// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps the coherence state of every line of a small, directly indexed cache and turns each event into the matching bus actions. Each line is in one of four states: Invalid, Shared, Exclusive or Modified. The block takes two kinds of event. Local events come from the processor: read, write and evict. Snooped events come from the shared bus: bus read, bus write and bus upgrade. For each event the block decides the new state of the line and the actions that go with it. Those actions are a bus command to issue, a shared or dirty snoop response, a writeback request, or an error when a bus upgrade could not legally happen.

Each line holds a tag, and an address is split into a tag and an index. A snoop whose tag does not match the stored tag sees the line as Invalid. A local access whose tag does not match also sees the line as Invalid. If that access replaces a line in Modified, the block writes the old line back.

The local event port is a valid/ready handshake. `loc_ready` drops in any cycle in which a snoop is presented, because snoops always win. A local request that is held with `loc_valid` is taken in the first cycle with no snoop. `sharer_in` is the bus's sharer indication, and it is sampled together with the local read that misses. The data arrays and bus arbitration lie outside this block.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid and all outputs are low: `bus_cmd_valid`, `snp_shared`, `snp_dirty`, `wb_req`, `err`, and the address outputs at zero.
- R2: A local read (op 0) to an Invalid line issues a bus read (command 0). The line fills to Exclusive when `sharer_in` is low and to Shared when it is high.
- R3: A local write (op 1) to an Invalid line issues a bus write (command 1) and the line becomes Modified. Snoops that find a line Invalid produce no output and no state change.
- R4: In Shared, a local read does nothing. A local write issues a bus upgrade (command 2) and the line becomes Modified. A snooped bus read gives `snp_shared` and the line stays Shared. A snooped bus write or bus upgrade makes the line Invalid.
- R5: In Exclusive, a local read does nothing. A local write moves the line to Modified with no bus command. A snooped bus read gives `snp_shared` and the line becomes Shared. A snooped bus write makes the line Invalid.
- R6: In Modified, a local read or write produces no output. An evict (op 2) raises `wb_req` with the line address and makes the line Invalid.
- R7: In Modified, a snooped bus read gives `snp_dirty` and `wb_req` and the line becomes Shared. A snooped bus write gives `snp_dirty` and `wb_req` and the line becomes Invalid. In both cases `wb_addr` is the snooped address.
- R8: A snooped bus upgrade (op 2) that hits a line in Exclusive or Modified pulses `err` and leaves the state unchanged.
- R9: An evict from Shared or Exclusive makes the line Invalid without a writeback. An evict that misses has no effect.
- R10: While `snp_valid` is high, `loc_ready` is low and the local event is not performed. Only the snoop acts in that cycle.
- R11: A snoop whose tag differs from the stored tag is treated as Invalid: no response and no state change.
- R12: A local read or write whose tag misses is handled as if the line were Invalid, and the new tag is stored. If the line it replaces was Modified, `wb_req` rises with `wb_addr` holding the old tag and the index, in the same cycle as the bus command.
- R13: Every output is registered. It appears in the cycle after the accepted event and lasts one cycle. Local op 3 and snoop op 3 do nothing. An address output is zero while its valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local event request |
| loc_ready | output | 1 | Local event accepted (low while a snoop is present) |
| loc_op | input | 2 | 0 read, 1 write, 2 evict, 3 none |
| loc_addr | input | ADDR_W | Local address (tag above index) |
| sharer_in | input | 1 | Another cache holds the line (for read fill) |
| snp_valid | input | 1 | Snooped bus event present |
| snp_op | input | 2 | 0 bus read, 1 bus write, 2 bus upgrade, 3 none |
| snp_addr | input | ADDR_W | Snooped address |
| bus_cmd_valid | output | 1 | Bus command to issue |
| bus_cmd | output | 2 | 0 bus read, 1 bus write, 2 bus upgrade |
| bus_addr | output | ADDR_W | Address of the bus command |
| snp_shared | output | 1 | Shared snoop response |
| snp_dirty | output | 1 | Dirty snoop response |
| wb_req | output | 1 | Writeback request |
| wb_addr | output | ADDR_W | Writeback line address |
| err | output | 1 | Illegal bus upgrade snooped |

## Verification
The hardest case to reach from the ports is a replacement of a Modified line. It needs a write to one tag and then a local access to another tag at the same index, with no snoop in between that knocks the line out of Modified. A directed sequence builds this case on purpose. The random phase then draws addresses from only two tags and a few indices, so that hits, misses, snoop–local collisions and upgrade errors on Exclusive or Modified lines all happen often.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  typedef enum logic [1:0] {ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3} mesi_t;
  localparam logic [1:0] LOC_RD = 2'd0;
  localparam logic [1:0] LOC_WR = 2'd1;
  localparam logic [1:0] LOC_EV = 2'd2;
  localparam logic [1:0] BUS_RD = 2'd0;
  localparam logic [1:0] BUS_WR = 2'd1;
  localparam logic [1:0] BUS_UP = 2'd2;
endpackage

// File: rtl/mesi_tag_array.sv
module mesi_tag_array
  import mesi_pkg::*;
#(
  parameter int INDEX_W = 3,
  parameter int TAG_W   = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] a_idx,
  output mesi_t              a_state,
  output logic [TAG_W-1:0]   a_tag,
  input  logic [INDEX_W-1:0] b_idx,
  output mesi_t              b_state,
  output logic [TAG_W-1:0]   b_tag,
  input  logic               we,
  input  logic [INDEX_W-1:0] w_idx,
  input  mesi_t              w_state,
  input  logic               w_tag_en,
  input  logic [TAG_W-1:0]   w_tag
);
  localparam int LINES = 1 << INDEX_W;

  mesi_t            state_q [LINES];
  logic [TAG_W-1:0] tag_q   [LINES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        state_q[i] <= ST_I;
        tag_q[i]   <= '0;
      end
    end else if (we) begin
      state_q[w_idx] <= w_state;
      if (w_tag_en) tag_q[w_idx] <= w_tag;
    end
  end

  assign a_state = state_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign b_state = state_q[b_idx];
  assign b_tag   = tag_q[b_idx];
endmodule

// File: rtl/mesi_next_state.sv
module mesi_next_state
  import mesi_pkg::*;
(
  input  logic       act,
  input  logic       is_snoop,
  input  logic [1:0] op,
  input  mesi_t      cur,
  input  logic       sharer,
  output mesi_t      nxt,
  output logic       cmd_v,
  output logic [1:0] cmd,
  output logic       rsp_sh,
  output logic       rsp_dt,
  output logic       wb,
  output logic       bad
);
  always_comb begin
    nxt = cur; cmd_v = 1'b0; cmd = 2'd0;
    rsp_sh = 1'b0; rsp_dt = 1'b0; wb = 1'b0; bad = 1'b0;
    if (act && !is_snoop) begin
      unique case (cur)
        ST_I: begin
          if (op == LOC_RD) begin
            cmd_v = 1'b1; cmd = BUS_RD; nxt = sharer ? ST_S : ST_E;
          end else if (op == LOC_WR) begin
            cmd_v = 1'b1; cmd = BUS_WR; nxt = ST_M;
          end
        end
        ST_S: begin
          if (op == LOC_WR) begin
            cmd_v = 1'b1; cmd = BUS_UP; nxt = ST_M;
          end else if (op == LOC_EV) nxt = ST_I;
        end
        ST_E: begin
          if (op == LOC_WR) nxt = ST_M;
          else if (op == LOC_EV) nxt = ST_I;
        end
        ST_M: begin
          if (op == LOC_EV) begin
            wb = 1'b1; nxt = ST_I;
          end
        end
        default: ;
      endcase
    end else if (act && is_snoop) begin
      unique case (cur)
        ST_I: ;
        ST_S: begin
          if (op == BUS_RD) rsp_sh = 1'b1;
          else if (op == BUS_WR || op == BUS_UP) nxt = ST_I;
        end
        ST_E: begin
          if (op == BUS_RD) begin rsp_sh = 1'b1; nxt = ST_S; end
          else if (op == BUS_WR) nxt = ST_I;
          else if (op == BUS_UP) bad = 1'b1;
        end
        ST_M: begin
          if (op == BUS_RD) begin rsp_dt = 1'b1; wb = 1'b1; nxt = ST_S; end
          else if (op == BUS_WR) begin rsp_dt = 1'b1; wb = 1'b1; nxt = ST_I; end
          else if (op == BUS_UP) bad = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl
  import mesi_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int INDEX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loc_valid,
  output logic              loc_ready,
  input  logic [1:0]        loc_op,
  input  logic [ADDR_W-1:0] loc_addr,
  input  logic              sharer_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_op,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              bus_cmd_valid,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              snp_shared,
  output logic              snp_dirty,
  output logic              wb_req,
  output logic [ADDR_W-1:0] wb_addr,
  output logic              err
);
  localparam int TAG_W = ADDR_W - INDEX_W;

  logic [INDEX_W-1:0] idx_l, idx_s;
  logic [TAG_W-1:0]   tag_l, tag_s, stag_l, stag_s;
  mesi_t              st_l, st_s, eff_l, eff_s, cur, nxt;
  logic               hit_l, hit_s, fire_l, fire_s, act, victim, we;
  logic               cmd_v, rsp_sh, rsp_dt, wb, bad;
  logic [1:0]         cmd, op;

  assign idx_l = loc_addr[INDEX_W-1:0];
  assign tag_l = loc_addr[ADDR_W-1:INDEX_W];
  assign idx_s = snp_addr[INDEX_W-1:0];
  assign tag_s = snp_addr[ADDR_W-1:INDEX_W];

  mesi_tag_array #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n),
    .a_idx(idx_l), .a_state(st_l), .a_tag(stag_l),
    .b_idx(idx_s), .b_state(st_s), .b_tag(stag_s),
    .we(we), .w_idx(fire_s ? idx_s : idx_l), .w_state(nxt),
    .w_tag_en(!fire_s), .w_tag(tag_l)
  );

  assign hit_l  = (st_l != ST_I) && (stag_l == tag_l);
  assign hit_s  = (st_s != ST_I) && (stag_s == tag_s);
  assign eff_l  = hit_l ? st_l : ST_I;
  assign eff_s  = hit_s ? st_s : ST_I;
  assign fire_s = snp_valid;
  assign loc_ready = !snp_valid;
  assign fire_l = loc_valid && loc_ready;
  assign act    = fire_s || fire_l;
  assign cur    = fire_s ? eff_s : eff_l;
  assign op     = fire_s ? snp_op : loc_op;

  mesi_next_state u_ns (
    .act(act), .is_snoop(fire_s), .op(op), .cur(cur), .sharer(sharer_in),
    .nxt(nxt), .cmd_v(cmd_v), .cmd(cmd), .rsp_sh(rsp_sh), .rsp_dt(rsp_dt),
    .wb(wb), .bad(bad)
  );

  always_comb begin
    victim = 1'b0;
    we     = 1'b0;
    if (fire_s) begin
      we = hit_s;
    end else if (fire_l) begin
      if (loc_op == LOC_RD || loc_op == LOC_WR) begin
        we     = 1'b1;
        victim = !hit_l && (st_l == ST_M);
      end else if (loc_op == LOC_EV) begin
        we = hit_l;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_cmd_valid <= 1'b0;
      bus_cmd       <= '0;
      bus_addr      <= '0;
      snp_shared    <= 1'b0;
      snp_dirty     <= 1'b0;
      wb_req        <= 1'b0;
      wb_addr       <= '0;
      err           <= 1'b0;
    end else begin
      bus_cmd_valid <= cmd_v;
      bus_cmd       <= cmd_v ? cmd : 2'd0;
      bus_addr      <= cmd_v ? loc_addr : '0;
      snp_shared    <= rsp_sh;
      snp_dirty     <= rsp_dt;
      wb_req        <= wb || victim;
      if (victim)  wb_addr <= {stag_l, idx_l};
      else if (wb) wb_addr <= fire_s ? snp_addr : loc_addr;
      else         wb_addr <= '0;
      err           <= bad;
    end
  end
endmodule

// File: rtl/mesi_line_ctrl_chk.sv
module mesi_line_ctrl_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loc_valid,
  input logic              loc_ready,
  input logic              snp_valid,
  input logic [1:0]        snp_op,
  input logic              bus_cmd_valid,
  input logic              snp_shared,
  input logic              snp_dirty,
  input logic              wb_req,
  input logic              err
);
  // R7
  dirty_has_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_dirty |-> wb_req);
  // R4
  single_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(snp_shared && snp_dirty));
  // R8
  err_from_upgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> $past(snp_valid && snp_op == 2'd2));
  // R10
  snoop_blocks_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |=> !bus_cmd_valid);
  // R13
  cmd_from_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cmd_valid |-> $past(loc_valid && loc_ready));
endmodule

bind mesi_line_ctrl mesi_line_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .loc_valid(loc_valid), .loc_ready(loc_ready),
  .snp_valid(snp_valid), .snp_op(snp_op), .bus_cmd_valid(bus_cmd_valid),
  .snp_shared(snp_shared), .snp_dirty(snp_dirty), .wb_req(wb_req), .err(err)
);

// File: tb/mesi_line_ctrl_test.sv
module mesi_line_ctrl_test;
  localparam int PERIOD = 10;
  localparam int AW = 16;
  localparam int IW = 3;
  localparam int NL = 1 << IW;

  logic clk = 0, rst_n = 0;
  logic loc_valid = 0, sharer_in = 0, snp_valid = 0;
  logic [1:0] loc_op = 0, snp_op = 0;
  logic [AW-1:0] loc_addr = 0, snp_addr = 0;
  logic loc_ready, bus_cmd_valid, snp_shared, snp_dirty, wb_req, err;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr, wb_addr;

  int total = 0, bad = 0;

  // reference: 0 I, 1 S, 2 E, 3 M
  int m_st [NL];
  logic [AW-IW-1:0] m_tag [NL];

  logic e_cv, e_sh, e_dt, e_wb, e_err;
  logic [1:0] e_cmd;
  logic [AW-1:0] e_ba, e_wa;
  string req;

  always #(PERIOD/2) clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(AW), .INDEX_W(IW)) uut (.*);

  initial begin
    #(PERIOD * 200000);
    bad++; total++;
    $display("FAIL watchdog: run did not finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [AW-1:0] mk(int t, int i);
    return {t[AW-IW-1:0], i[IW-1:0]};
  endfunction

  task automatic model(input logic lv, input logic [1:0] lop, input logic [AW-1:0] la,
                       input logic sv, input logic [1:0] sop, input logic [AW-1:0] sa,
                       input logic sh);
    int i, s;
    logic hit;
    e_cv = 0; e_cmd = 0; e_ba = 0; e_sh = 0; e_dt = 0; e_wb = 0; e_wa = 0; e_err = 0;
    req = "R13";
    if (sv) begin
      i = int'(sa[IW-1:0]);
      hit = (m_st[i] != 0) && (m_tag[i] == sa[AW-1:IW]);
      if (!hit) req = (m_st[i] != 0) ? "R11" : "R3";
      else begin
        s = m_st[i];
        case (s)
          1: begin req = "R4";
            if (sop == 0) e_sh = 1; else if (sop == 1 || sop == 2) m_st[i] = 0; end
          2: begin req = "R5";
            if (sop == 0) begin e_sh = 1; m_st[i] = 1; end
            else if (sop == 1) m_st[i] = 0;
            else if (sop == 2) begin e_err = 1; req = "R8"; end end
          default: begin req = "R7";
            if (sop == 0) begin e_dt = 1; e_wb = 1; e_wa = sa; m_st[i] = 1; end
            else if (sop == 1) begin e_dt = 1; e_wb = 1; e_wa = sa; m_st[i] = 0; end
            else if (sop == 2) begin e_err = 1; req = "R8"; end end
        endcase
      end
    end else if (lv && lop != 3) begin
      i = int'(la[IW-1:0]);
      hit = (m_st[i] != 0) && (m_tag[i] == la[AW-1:IW]);
      if (lop == 2) begin
        req = "R9";
        if (hit) begin
          if (m_st[i] == 3) begin e_wb = 1; e_wa = la; req = "R6"; end
          m_st[i] = 0;
        end
      end else if (!hit) begin
        req = (lop == 0) ? "R2" : "R3";
        if (m_st[i] == 3) begin e_wb = 1; e_wa = {m_tag[i], la[IW-1:0]}; req = "R12"; end
        e_cv = 1; e_ba = la;
        e_cmd = (lop == 0) ? 2'd0 : 2'd1;
        m_st[i] = (lop == 1) ? 3 : (sh ? 1 : 2);
        m_tag[i] = la[AW-1:IW];
      end else begin
        case (m_st[i])
          1: begin req = "R4"; if (lop == 1) begin e_cv = 1; e_cmd = 2; e_ba = la; m_st[i] = 3; end end
          2: begin req = "R5"; if (lop == 1) m_st[i] = 3; end
          default: req = "R6";
        endcase
      end
    end
  endtask

  task automatic step(input logic lv, input logic [1:0] lop, input logic [AW-1:0] la,
                      input logic sv, input logic [1:0] sop, input logic [AW-1:0] sa,
                      input logic sh);
    @(negedge clk);
    loc_valid = lv; loc_op = lop; loc_addr = la;
    snp_valid = sv; snp_op = sop; snp_addr = sa; sharer_in = sh;
    #1;
    if (sv) begin
      total++;
      if (loc_ready !== 1'b0) begin
        bad++;
        $display("FAIL R10: loc_ready=%0b expected 0", loc_ready);
      end
    end
    model(lv, lop, la, sv, sop, sa, sh);
    @(negedge clk);
    total++;
    if ({bus_cmd_valid, bus_cmd, bus_addr, snp_shared, snp_dirty, wb_req, wb_addr, err} !==
        {e_cv, e_cmd, e_ba, e_sh, e_dt, e_wb, e_wa, e_err}) begin
      bad++;
      $display("FAIL %s: got cv=%0b cmd=%0d ba=%h sh=%0b dt=%0b wb=%0b wa=%h err=%0b exp cv=%0b cmd=%0d ba=%h sh=%0b dt=%0b wb=%0b wa=%h err=%0b",
               req, bus_cmd_valid, bus_cmd, bus_addr, snp_shared, snp_dirty, wb_req, wb_addr, err,
               e_cv, e_cmd, e_ba, e_sh, e_dt, e_wb, e_wa, e_err);
    end
    loc_valid = 0; snp_valid = 0;
  endtask

  initial begin
    logic [AW-1:0] a, b, c, d;
    int unsigned seed;
    for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    total++;
    // R1: outputs idle after reset
    if ({bus_cmd_valid, snp_shared, snp_dirty, wb_req, err, bus_addr, wb_addr} !== '0) begin
      bad++; $display("FAIL R1: outputs not idle after reset");
    end
    a = mk(1, 2); b = mk(1, 5); c = mk(2, 5); d = mk(1, 0);
    // R1: lines Invalid, snoop gets no response
    step(0, 0, 0, 1, 0, a, 0);
    step(0, 0, 0, 1, 1, mk(0, 0), 0);
    step(1, 0, a, 0, 0, 0, 0);   // R2 -> E
    step(1, 0, a, 0, 0, 0, 0);   // R5 read hit
    step(0, 0, 0, 1, 2, a, 0);   // R8 upgrade on E
    step(0, 0, 0, 1, 0, a, 0);   // R5 -> S
    step(0, 0, 0, 1, 0, a, 0);   // R4 stays S
    step(1, 1, a, 0, 0, 0, 0);   // R4 upgrade -> M
    step(0, 0, 0, 1, 2, a, 0);   // R8 upgrade on M
    step(0, 0, 0, 1, 0, mk(2, 2), 0); // R11 tag miss
    step(0, 0, 0, 1, 0, a, 0);   // R7 dirty -> S
    step(1, 0, b, 0, 0, 0, 1);   // R2 -> S
    step(0, 0, 0, 1, 1, b, 0);   // R4 -> I
    step(1, 1, b, 0, 0, 0, 0);   // R3 -> M
    step(1, 0, c, 0, 0, 0, 0);   // R12 victim writeback
    step(1, 1, c, 1, 1, c, 0);   // R10 snoop wins -> I
    step(1, 1, c, 0, 0, 0, 0);   // retry -> bus write
    step(1, 2, a, 0, 0, 0, 0);   // R9 evict S
    step(0, 0, 0, 1, 0, a, 0);
    step(1, 1, d, 0, 0, 0, 0);
    step(1, 0, d, 0, 0, 0, 0);   // R6 read in M
    step(1, 2, d, 0, 0, 0, 0);   // R6 evict writeback
    step(1, 3, d, 1, 3, d, 0);   // R13 no-op codes
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int n = 0; n < 3000; n++) begin
      logic lv, sv, sh;
      logic [1:0] lop, sop;
      lv  = ($urandom % 4) != 0;
      sv  = ($urandom % 3) == 0;
      sh  = $urandom % 2;
      lop = $urandom % 4;
      sop = $urandom % 4;
      step(lv, lop, mk(1 + $urandom % 2, $urandom % 4), sv, sop,
           mk(1 + $urandom % 2, $urandom % 4), sh);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule